// File: doc/BRIEF.md
# Keyed Entry Stack with Two-Ended Push and Pop

This block holds a small, fixed number of 16-bit configuration entries, packed from slot 0 upward. Each write carries one 16-bit value and a flag that selects the top or the bottom end. The value decides what the write does. A zero value removes an entry. A nonzero value whose 5-bit key is already held replaces that entry where it sits. Any other nonzero value is inserted at the selected end.

Whenever an entry leaves the array, the block hands it back on a one-cycle response. This happens when an entry is popped, and when an insert into a full array pushes one out at the far end. The caller can then save that entry or discard it. There is one write per cycle, with a valid/ready handshake on the request side and a done pulse on the response side.

Top module: `ks_stack`

## Requirements
- R1: After reset every slot is empty, `req_ready` and `rsp_done` are low and `rsp_value` is 0. A slot holding 0x0000 is empty, and occupied slots always form a contiguous run starting at slot 0. The key of an entry is bits [4:0] of its value.
- R2: An accepted nonzero value whose key is nonzero and equal to the key of an occupied slot overwrites that slot. No other slot changes, the entry count stays the same, and the response value is 0.
- R3: An accepted nonzero value at the top end (`req_at_top`=1) that matches no key, into an array that is not full, is placed in the lowest empty slot. The response value is 0.
- R4: A top-end insert into a full array removes slot 0 and moves every other entry down one slot. The new value goes into the highest slot, and the removed slot-0 entry is the response value.
- R5: A bottom-end insert (`req_at_top`=0) that matches no key moves every entry up one slot and places the new value in slot 0. If the array was full, the entry pushed out of the highest slot is the response value. Otherwise the response value is 0.
- R6: A zero value at the top end clears the highest occupied slot and returns its entry. On an empty array it returns 0 and changes nothing.
- R7: A zero value at the bottom end returns the entry in slot 0 and moves the other entries down one slot, which empties the highest occupied slot. On an empty array it returns 0 and changes nothing.
- R8: A nonzero value whose key is 0 never matches any slot. It is always inserted, so several entries with key 0 can be held at the same time.
- R9: `req_ready` is high whenever the block is out of reset. A request is accepted in a cycle where `req_valid` and `req_ready` are both high. `rsp_done` is high for exactly the one cycle after each accepted request, and `rsp_value` holds that request's result in that cycle. Without an accepted request `rsp_done` stays low and no slot changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_value | input | 16 | Entry value; zero means remove |
| req_at_top | input | 1 | 1 selects the top end, 0 the bottom end |
| rsp_done | output | 1 | One-cycle pulse after an accepted request |
| rsp_value | output | 16 | Entry that left the array, or 0 |

## Verification
An insert into a full array is where two functions land in the same cycle. The new entry is placed, and the entry at the opposite end is forced out and returned as the result. The bench fills the array to its depth with distinct keys and then inserts at each end. It compares the returned entry and the later contents, seen by draining the array through bottom pops, with a queue model that inserts at one end and drops from the other. Key matching against a full array is also exercised, to confirm that an update there evicts nothing.

// File: rtl/ks_pkg.sv
package ks_pkg;

    localparam int ENTRY_W = 16;
    localparam int KEY_W   = 5;

    typedef logic [ENTRY_W-1:0] entry_t;
    typedef logic [KEY_W-1:0]   key_t;

    typedef enum logic [2:0] {
        OP_IDLE     = 3'd0,
        OP_UPDATE   = 3'd1,
        OP_INS_TOP  = 3'd2,
        OP_INS_BOT  = 3'd3,
        OP_REM_TOP  = 3'd4,
        OP_REM_BOT  = 3'd5
    } op_e;

    typedef struct packed {
        logic   fire;
        entry_t value;
        logic   at_top;
    } req_t;

    typedef struct packed {
        logic   done;
        entry_t value;
    } rsp_t;

    function automatic key_t key_of(entry_t e);
        return e[KEY_W-1:0];
    endfunction

    function automatic logic slot_used(entry_t e);
        return e != '0;
    endfunction

endpackage

// File: rtl/ks_occupancy.sv
module ks_occupancy
    import ks_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  entry_t [DEPTH-1:0] slots,
    input  entry_t             probe,
    output logic   [CNT_W-1:0] fill,
    output logic   [DEPTH-1:0] hit,
    output logic               full,
    output logic               empty
);

    logic [DEPTH-1:0] nz;
    logic [DEPTH-1:0] occ;
    logic             probe_keyed;

    assign probe_keyed = key_of(probe) != '0;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        assign nz[g]  = slot_used(slots[g]);
        assign occ[g] = &nz[g:0];
        assign hit[g] = occ[g] && probe_keyed && (key_of(slots[g]) == key_of(probe));
    end

    always_comb begin
        fill = '0;
        for (int i = 0; i < DEPTH; i++) begin
            fill = fill + CNT_W'(occ[i]);
        end
    end

    assign full  = occ[DEPTH-1];
    assign empty = ~nz[0];

endmodule

// File: rtl/ks_classify.sv
module ks_classify
    import ks_pkg::*;
(
    input  req_t req,
    input  logic any_hit,
    output op_e  op
);

    always_comb begin
        op = OP_IDLE;
        if (req.fire) begin
            if (req.value == '0) begin
                op = req.at_top ? OP_REM_TOP : OP_REM_BOT;
            end else if (any_hit) begin
                op = OP_UPDATE;
            end else begin
                op = req.at_top ? OP_INS_TOP : OP_INS_BOT;
            end
        end
    end

endmodule

// File: rtl/ks_next.sv
module ks_next
    import ks_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  entry_t [DEPTH-1:0] slots,
    input  op_e                op,
    input  entry_t             value,
    input  logic   [CNT_W-1:0] fill,
    input  logic   [DEPTH-1:0] hit,
    input  logic               full,
    input  logic               empty,
    output entry_t [DEPTH-1:0] slots_nxt,
    output entry_t             out_value
);

    localparam int LAST = DEPTH - 1;

    logic [CNT_W-1:0] top_idx;
    assign top_idx = fill - CNT_W'(1);

    always_comb begin
        slots_nxt = slots;
        out_value = '0;
        unique case (op)
            OP_UPDATE: begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (hit[i]) slots_nxt[i] = value;
                end
            end
            OP_INS_TOP: begin
                if (full) begin
                    out_value = slots[0];
                    for (int i = 0; i < LAST; i++) begin
                        slots_nxt[i] = slots[i+1];
                    end
                    slots_nxt[LAST] = value;
                end else begin
                    for (int i = 0; i < DEPTH; i++) begin
                        if (CNT_W'(i) == fill) slots_nxt[i] = value;
                    end
                end
            end
            OP_INS_BOT: begin
                if (full) out_value = slots[LAST];
                for (int i = 1; i < DEPTH; i++) begin
                    slots_nxt[i] = slots[i-1];
                end
                slots_nxt[0] = value;
            end
            OP_REM_TOP: begin
                if (!empty) begin
                    for (int i = 0; i < DEPTH; i++) begin
                        if (CNT_W'(i) == top_idx) begin
                            out_value    = slots[i];
                            slots_nxt[i] = '0;
                        end
                    end
                end
            end
            OP_REM_BOT: begin
                out_value = slots[0];
                for (int i = 0; i < LAST; i++) begin
                    slots_nxt[i] = slots[i+1];
                end
                slots_nxt[LAST] = '0;
            end
            default: begin
                slots_nxt = slots;
            end
        endcase
    end

endmodule

// File: rtl/ks_stack.sv
module ks_stack
    import ks_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [15:0] req_value,
    input  logic        req_at_top,
    output logic        rsp_done,
    output logic [15:0] rsp_value
);

    entry_t [DEPTH-1:0] slots_q;
    entry_t [DEPTH-1:0] slots_nxt;
    logic               ready_q;
    rsp_t               rsp_q;
    req_t               req;
    op_e                op;
    entry_t             out_value;
    logic   [CNT_W-1:0] fill;
    logic   [DEPTH-1:0] hit;
    logic               full;
    logic               empty;

    assign req.fire   = req_valid && ready_q;
    assign req.value  = entry_t'(req_value);
    assign req.at_top = req_at_top;

    ks_occupancy #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_occ (
        .slots (slots_q),
        .probe (req.value),
        .fill  (fill),
        .hit   (hit),
        .full  (full),
        .empty (empty)
    );

    ks_classify u_cls (
        .req     (req),
        .any_hit (|hit),
        .op      (op)
    );

    ks_next #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_nxt (
        .slots     (slots_q),
        .op        (op),
        .value     (req.value),
        .fill      (fill),
        .hit       (hit),
        .full      (full),
        .empty     (empty),
        .slots_nxt (slots_nxt),
        .out_value (out_value)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            slots_q <= '0;
            ready_q <= 1'b0;
            rsp_q   <= '0;
        end else begin
            slots_q    <= slots_nxt;
            ready_q    <= 1'b1;
            rsp_q.done <= req.fire;
            rsp_q.value <= req.fire ? out_value : '0;
        end
    end

    assign req_ready = ready_q;
    assign rsp_done  = rsp_q.done;
    assign rsp_value = rsp_q.value;

    for (genvar g = 0; g < DEPTH - 1; g++) begin : g_chk_pack
        AST_PACKED_RUN: assert property (@(posedge clk) disable iff (rst)
            (slots_q[g] == '0) |-> (slots_q[g+1] == '0)); // R1
    end

    AST_KEY_UNIQUE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit)); // R2

    AST_UPDATE_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (op == OP_UPDATE) |=> (fill == $past(fill)) && (rsp_value == '0)); // R2

    AST_TOP_GROWS: assert property (@(posedge clk) disable iff (rst)
        (op == OP_INS_TOP && !full) |=> (fill == $past(fill) + CNT_W'(1)) && (rsp_value == '0)); // R3

    AST_TOP_EVICT: assert property (@(posedge clk) disable iff (rst)
        (op == OP_INS_TOP && full) |=> full && (rsp_value == $past(slots_q[0]))); // R4

    AST_BOT_EVICT: assert property (@(posedge clk) disable iff (rst)
        (op == OP_INS_BOT && full) |=> full && (slots_q[0] == $past(req.value))); // R5

    AST_POP_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (op == OP_REM_TOP && empty) |=> (rsp_value == '0) && empty); // R6

    AST_BOT_POP_SHRINK: assert property (@(posedge clk) disable iff (rst)
        (op == OP_REM_BOT && !empty) |=> (fill == $past(fill) - CNT_W'(1))); // R7

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        req.fire |=> rsp_done); // R9

    AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (rst)
        !req.fire |=> !rsp_done && $stable(slots_q)); // R9

endmodule

// File: tb/ks_stack_tb.sv
`timescale 1ns/1ps
module ks_stack_tb;

    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_value = '0;
    logic        req_at_top = 1'b0;
    logic        rsp_done;
    logic [15:0] rsp_value;

    int checks = 0;
    int bad    = 0;
    logic [15:0] ref_q[$];

    always #4 clk = ~clk;

    ks_stack #(.DEPTH(DEPTH)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_value  (req_value),
        .req_at_top (req_at_top),
        .rsp_done   (rsp_done),
        .rsp_value  (rsp_value)
    );

    task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic model(input logic [15:0] v, input logic top,
                         output logic [15:0] exp, output string tag);
        int found;
        exp   = '0;
        found = -1;
        if (v == 16'h0) begin
            tag = top ? "R6" : "R7";
            if (ref_q.size() != 0) exp = top ? ref_q.pop_back() : ref_q.pop_front();
            return;
        end
        if (v[4:0] != 5'd0) begin
            foreach (ref_q[i]) if (ref_q[i][4:0] == v[4:0]) found = i;
        end
        if (found >= 0) begin
            tag = "R2";
            ref_q[found] = v;
        end else if (top) begin
            tag = (v[4:0] == 5'd0) ? "R8" : (ref_q.size() == DEPTH ? "R4" : "R3");
            if (ref_q.size() == DEPTH) exp = ref_q.pop_front();
            ref_q.push_back(v);
        end else begin
            tag = (v[4:0] == 5'd0) ? "R8" : "R5";
            if (ref_q.size() == DEPTH) exp = ref_q.pop_back();
            ref_q.push_front(v);
        end
    endtask

    task automatic apply(input logic [15:0] v, input logic top);
        logic [15:0] exp;
        string tag;
        model(v, top, exp, tag);
        req_valid  = 1'b1;
        req_value  = v;
        req_at_top = top;
        @(negedge clk);
        check(tag, "done", {15'b0, rsp_done}, 16'd1);
        check(tag, "value", rsp_value, exp);
        req_valid = 1'b0;
    endtask

    task automatic idle();
        req_valid = 1'b0;
        @(negedge clk);
        check("R9", "idle done", {15'b0, rsp_done}, 16'd0);
    endtask

    task automatic drain();
        for (int k = 0; k <= DEPTH; k++) apply(16'h0, 1'b0);
    endtask

    initial begin
        #(8 * 200000);
        bad++;
        $display("FAIL R9 watchdog actual=%h expected=%h", 16'h1, 16'h0);
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        // requests during reset must be ignored (R9)
        req_valid = 1'b1;
        req_value = 16'h0111;
        req_at_top = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", "ready in reset", {15'b0, req_ready}, 16'd0);
        check("R1", "done in reset", {15'b0, rsp_done}, 16'd0);
        rst = 1'b0;
        req_valid = 1'b0;
        @(negedge clk);
        check("R1", "value after reset", rsp_value, 16'h0);
        check("R9", "ready after reset", {15'b0, req_ready}, 16'd1);

        // empty array pops
        apply(16'h0, 1'b0);     // R7 empty
        apply(16'h0, 1'b1);     // R6 empty
        idle();

        // basic top pushes, update, pop
        apply(16'h0101, 1'b1);  // R3
        apply(16'h0202, 1'b1);  // R3
        apply(16'h0303, 1'b1);  // R3
        apply(16'h1102, 1'b1);  // R2 key 2
        apply(16'h0, 1'b1);     // R6 returns 0303
        apply(16'h0404, 1'b0);  // R5 not full
        apply(16'h0020, 1'b1);  // R8 key 0
        apply(16'h0040, 1'b1);  // R8 key 0 again
        idle();

        // fill and overflow at both ends
        apply(16'h0505, 1'b1);
        apply(16'h0606, 1'b1);
        apply(16'h0707, 1'b1);  // now full
        apply(16'h0808, 1'b1);  // R4 evicts bottom
        apply(16'h0909, 1'b0);  // R5 evicts top
        apply(16'h2206, 1'b0);  // R2 update while full
        apply(16'h0a0a, 1'b1);  // R4 again
        drain();                // R7 contents check
        idle();

        // reverse orientation fill and top drain
        for (int k = 1; k <= DEPTH + 2; k++) apply(16'h0100 * k[15:0] + k[15:0], 1'b0);
        for (int k = 0; k <= DEPTH; k++) apply(16'h0, 1'b1);

        // mixed random traffic with a small key space
        for (int n = 0; n < 400; n++) begin
            logic [15:0] v;
            int r;
            r = $urandom_range(0, 9);
            v = {$urandom_range(0, 255), 3'b000, 5'($urandom_range(0, 7))};
            if (r < 3) v = 16'h0;
            if (v == 16'h0 && r >= 3) v = 16'h0100;
            if (r == 9) idle();
            else apply(v, $urandom_range(0, 1) == 1);
        end
        drain();
        idle();

        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule